// File: doc/BRIEF.md
# Skewed Bit-Pipelined Ripple Adder

This block adds two unsigned WIDTH-bit operands with a ripple-carry chain that is cut by a register after every full-adder stage. Each clock period therefore holds only one full-adder delay. Operand bit i is held back by i clock cycles so that it reaches its full adder in the same cycle as the carry from bit i-1. Sum bit i is then held for WIDTH-i further cycles, so that all sum bits and the final carry leave together.

A new operand pair can be presented on every clock. The sum of a pair, with its carry-out, appears exactly WIDTH clocks after the pair is presented. A valid flag runs beside the data through a WIDTH-deep shift register and marks which outputs belong to pairs the user flagged. The datapath itself computes on every clock, whatever the flag says.

Top module: `skew_ripple_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `a_in + b_in` for the pair presented exactly WIDTH rising edges earlier.
- R2: `carry_out` equals bit WIDTH (the carry beyond the top bit) of that same sum, and changes on the same edge as `sum_out`.
- R3: A different pair may be presented on every clock with no stall, and each of those back-to-back pairs yields its own correct result, one per clock.
- R4: `out_valid` equals the `in_valid` value that was presented WIDTH rising edges earlier.
- R5: `rst_n` is active-low and synchronous. It clears every operand-skew, carry and sum-deskew register. While reset is held, and for WIDTH-1 edges after it is released, `sum_out`, `carry_out` and `out_valid` read zero whatever the inputs are.
- R6: A carry that ripples through every bit position is handled at full rate. For example, all-ones plus one gives a sum of zero with `carry_out` set, and all-ones plus all-ones gives all-ones minus one with `carry_out` set.
- R7: The carry into bit 0 is a constant zero. Zero plus zero gives zero with `carry_out` clear, and zero plus X gives X.
- R8: `in_valid` does not gate the datapath. A pair presented with `in_valid` low still yields its sum and carry WIDTH edges later, with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| in_valid | input | 1 | Marks the presented pair as meaningful |
| sum_out | output | WIDTH | Sum of the pair presented WIDTH clocks earlier |
| carry_out | output | 1 | Carry beyond the top bit, aligned with `sum_out` |
| out_valid | output | 1 | `in_valid` delayed by WIDTH clocks |

## Verification
Each bit position has its own chain of skew and deskew registers. A fault in one of them makes a single sum bit come from the wrong operand pair, and that bit is wrong on the first result whose neighbouring pair differs in that bit. A missing or extra carry register mixes carries from adjacent pairs, so it corrupts the upper sum bits and `carry_out` as soon as long carry chains follow each other. For this reason every operand pair in the sweep is different from the one before it. A reset that fails to clear a register shows up as a nonzero output within the first WIDTH-1 edges after release.

// File: rtl/sra_pkg.sv
// Package: shared helpers for the skewed ripple adder.
// Holds the single-bit full-adder equations so every stage uses one definition.
package sra_pkg;

    // Sum output of a one-bit full adder: odd parity of the three inputs.
    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    // Carry output of a one-bit full adder: majority of the three inputs.
    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x | y));
    endfunction

endpackage

// File: rtl/sra_delay.sv
// Module: sra_delay
// A fixed-length register delay line for a WIDTH-bit word.
// Assumes DEPTH >= 1. Synchronous active-low reset clears every stage to zero.
module sra_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] line_q [DEPTH];

    // Shift the word one stage per clock, clearing all stages on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
        end else begin
            line_q[0] <= din;
            for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
        end
    end

    assign dout = line_q[DEPTH-1];

endmodule

// File: rtl/sra_slice.sv
// Module: sra_slice
// One bit position of the skewed adder. The operand bits are delayed IDX
// clocks, then added with the registered carry from the stage below. The carry
// is registered for the stage above, and the sum bit is delayed WIDTH-IDX
// clocks so that it leaves aligned with all other positions.
// Assumes 0 <= IDX < WIDTH and that cin_q is driven by the previous stage's
// carry register (or a constant zero for IDX == 0).
module sra_slice
    import sra_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic cin_q,
    output logic cout_q,
    output logic sum_bit
);

    localparam int DESKEW = WIDTH - IDX;

    logic a_d;
    logic b_d;
    logic s_comb;
    logic c_comb;

    // Operand skew: position IDX waits IDX clocks for its carry to arrive.
    generate
        if (IDX == 0) begin : g_no_skew
            assign a_d = a_bit;
            assign b_d = b_bit;
        end else begin : g_skew
            logic [1:0] pair_d;
            sra_delay #(.WIDTH(2), .DEPTH(IDX)) u_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  ({a_bit, b_bit}),
                .dout (pair_d)
            );
            assign a_d = pair_d[1];
            assign b_d = pair_d[0];
        end
    endgenerate

    // Full-adder equations for this position.
    always_comb begin
        s_comb = fa_sum(a_d, b_d, cin_q);
        c_comb = fa_carry(a_d, b_d, cin_q);
    end

    // Register the carry that feeds the next position up.
    always_ff @(posedge clk) begin
        if (!rst_n) cout_q <= 1'b0;
        else        cout_q <= c_comb;
    end

    // Sum deskew: hold the bit until every position has finished.
    sra_delay #(.WIDTH(1), .DEPTH(DESKEW)) u_deskew (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (s_comb),
        .dout (sum_bit)
    );

    // R1: the registered carry equals the arithmetic carry of last cycle's three inputs.
    a_r1_stage_carry: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cout_q == $past(((2'(a_d) + 2'(b_d)) + 2'(cin_q)) >> 1));

    // R7: bit 0 has no carry in, so its carry is just the AND of its operands.
    generate
        if (IDX == 0) begin : g_cin_check
            a_r7_stage0_cin: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> cout_q == $past(a_bit & b_bit));
        end
    endgenerate

endmodule

// File: rtl/skew_ripple_adder.sv
// Module: skew_ripple_adder
// Two-operand WIDTH-bit adder with a register after every full-adder stage.
// Operands are skewed by bit position on the way in and sums deskewed on the
// way out, so one result leaves per clock, WIDTH clocks after its operands.
// Assumes WIDTH >= 2. Synchronous active-low reset clears all pipeline state.
module skew_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             in_valid,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             out_valid
);

    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH:0] carry_q;

    // Carry into bit 0 is a constant zero.
    assign carry_q[0] = 1'b0;

    // One slice per bit position, chained through registered carries.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            sra_slice #(.WIDTH(WIDTH), .IDX(i)) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .a_bit  (a_in[i]),
                .b_bit  (b_in[i]),
                .cin_q  (carry_q[i]),
                .cout_q (carry_q[i+1]),
                .sum_bit(sum_out[i])
            );
        end
    endgenerate

    // The top carry register finishes on the same edge as the last deskew stage.
    assign carry_out = carry_q[WIDTH];

    // Valid flag travels beside the data through WIDTH registers.
    sra_delay #(.WIDTH(1), .DEPTH(WIDTH)) u_valid (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_valid),
        .dout (out_valid)
    );

    // Check support: edges since reset release, saturating at WIDTH.
    logic [CNT_W-1:0] since_rel_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_rel_q <= '0;
        else if (since_rel_q != CNT_W'(WIDTH)) since_rel_q <= since_rel_q + 1'b1;
    end

    // Check support: number of flagged pairs currently inside the pipeline.
    logic [CNT_W-1:0] occ_q;
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    // R5: until WIDTH edges have passed since release, nothing but zero leaves.
    a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rel_q < CNT_W'(WIDTH)) |-> (sum_out == '0 && !carry_out && !out_valid));

    // R4: a valid output needs a flagged pair in flight, and never more than WIDTH are.
    a_r4_valid_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        !(occ_q == '0 && out_valid) && (occ_q <= CNT_W'(WIDTH)));

endmodule

// File: tb/skew_ripple_adder_tb.sv
module skew_ripple_adder_tb;

    localparam int W    = 8;
    localparam int HIST = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         in_valid = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         out_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int since_rel = 0;

    logic [W-1:0] h_a   [HIST];
    logic [W-1:0] h_b   [HIST];
    logic         h_v   [HIST];
    int           h_tag [HIST];

    always #5 clk = ~clk;

    skew_ripple_adder #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (a_in),
        .b_in     (b_in),
        .in_valid (in_valid),
        .sum_out  (sum_out),
        .carry_out(carry_out),
        .out_valid(out_valid)
    );

    function automatic string req_of(input int tag);
        case (tag)
            3:       return "R3";
            6:       return "R6";
            7:       return "R7";
            8:       return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_zero();
        check("R5", {carry_out, sum_out}, '0);
        check("R5", {{W{1'b0}}, out_valid}, '0);
    endtask

    // Hold reset for k clocks, checking that outputs read zero once it has taken effect.
    task automatic reset_for(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (i > 0) check_zero();
            rst_n    = 1'b0;
            a_in     = W'($urandom);
            b_in     = W'($urandom);
            in_valid = 1'b1;
        end
        since_rel = 0;
    endtask

    // Sample the output due now, then present the next pair.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic v, input int tag);
        logic [W:0] exp;
        int slot;
        @(negedge clk);
        if (since_rel >= W) begin
            slot = (since_rel - W) % HIST;
            exp  = {1'b0, h_a[slot]} + {1'b0, h_b[slot]};
            check(req_of(h_tag[slot]), {1'b0, sum_out}, {1'b0, exp[W-1:0]});
            check("R2", {{W{1'b0}}, carry_out}, {{W{1'b0}}, exp[W]});
            check("R4", {{W{1'b0}}, out_valid}, {{W{1'b0}}, h_v[slot]});
        end else begin
            check_zero();
        end
        rst_n    = 1'b1;
        a_in     = a;
        b_in     = b;
        in_valid = v;
        slot = since_rel % HIST;
        h_a[slot] = a;
        h_b[slot] = b;
        h_v[slot] = v;
        h_tag[slot] = tag;
        since_rel++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        reset_for(4);
        // R6: full-length carry ripples; R7: zero carry into bit 0.
        step({W{1'b1}}, W'(1), 1'b1, 6);
        step('0, '0, 1'b1, 7);
        step({W{1'b1}}, {W{1'b1}}, 1'b1, 6);
        step(W'(1), {W{1'b1}}, 1'b1, 6);
        step('0, W'(8'h5A), 1'b1, 7);
        step(W'(8'h80), W'(8'h80), 1'b1, 6);
        // R3: back-to-back distinct pairs.
        for (int k = 0; k < 16; k++)
            step(W'(k * 17), W'(~(k * 29)), 1'b1, 3);
        // Exhaustive sweep; every seventh pair unflagged for R8.
        for (int idx = 0; idx < (1 << (2 * W)); idx++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            logic         v;
            a = W'(idx >> W);
            b = W'(idx) ^ W'(a * 37);
            v = (idx % 7) != 3;
            step(a, b, v, v ? 1 : 8);
        end
        // R5: reset in the middle of traffic, then refill.
        reset_for(3);
        for (int k = 0; k < 3 * W; k++)
            step(W'($urandom), W'($urandom), k[0], k[0] ? 1 : 8);
        for (int k = 0; k < W + 1; k++)
            step('0, '0, 1'b0, 7);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule